// File: doc/BRIEF.md
# Combo PHY Bring-Up Sequencer

This block powers up a combined USB / DisplayPort physical layer after a single `start` pulse. It holds five reset lines and a power enable for the PHY. First it turns on low-frequency periodic signalling reception, but only when USB is selected. It then switches on power and frees the register-bus resets. Next it replays a built-in list of register writes through a plain write port, with a per-entry pause after each write. After the list it programs which lanes carry DisplayPort. It then frees the core resets according to the selected modes and, for USB, polls the PHY's status words until the PLL and the receive clock recovery report lock.

The list is generated inside the block from a closed formula, so no memory file is needed. A PLL that never locks rolls the resets back in a fixed two-step order and raises `error`. A clock-recovery lock that never arrives still lets the bring-up finish, but it is flagged on `cdr_late`. Reads use a one-cycle-latency port. Every wait is counted in clock cycles, with `CYC_PER_US` converting microsecond table delays.

Top module: `phy_bringup_seq`

## Requirements
- R1: After reset all five reset holds are 1, `pwr_en` and `lfps_en` are 0, and `wr_en`, `rd_en`, `done`, `error` and `cdr_late` are 0.
- R2: On `start` all holds are re-asserted and power is turned off. Then `lfps_en` rises (USB mode only), then `pwr_en` rises, then `hold_pma_bus` falls, then `hold_pcs_bus` falls, each in a later cycle, and all of this happens before the first write.
- R3: Table entry i (i = 0 .. TBL_DEPTH-1) is written in index order. Its address is 0x100 + 4*i, its data is (37*i + 5) mod 256, and its delay is (i mod 4)+1 µs when i mod 3 = 1 and 0 otherwise.
- R4: The distance in cycles between the write of entry i and that of entry i+1 is at least delay(i)*CYC_PER_US and at most that plus 2.
- R5: After the table, one write to 0x288 carries data {4'b0000 lane enables, mux[3:0]}, where mux bit n = 1 means lane n carries DisplayPort. The mux is 1100 for USB+DP unflipped, 0011 for USB+DP flipped, 1111 for DP only and 0000 otherwise.
- R6: After the mux write, `hold_init` falls only in USB mode. In DP mode a write of 0x01 to 0x28C is made instead, and no write to 0x28C occurs without DP mode.
- R7: `hold_cmn` and `hold_lane` fall only in USB mode, at least SETTLE_CYC (= CYC_PER_US) cycles after the init release.
- R8: Without USB mode no status read is made, and `done` pulses after the init step.
- R9: The PLL status at 0x0F0 passes only when bits 1 and 0 are both 1. Reads are single-cycle strobes at least POLL_GAP cycles apart, with at most POLL_MAX attempts.
- R10: After the PLL passes, clock recovery is polled at 0x8F0 (bit 0) when unflipped and at 0x9F0 (bit 0) when flipped. Running out of attempts still gives `done`, with `cdr_late` = 1 in the same cycle.
- R11: When the PLL runs out of attempts, `hold_init`, `hold_cmn` and `hold_lane` rise together, `hold_pma_bus` and `hold_pcs_bus` rise one cycle later, and `error` pulses with them.
- R12: `done` and `error` are single-cycle pulses that never coincide, exactly one per run. `start`, and any change of the mode inputs, while a run is in progress has no effect on the writes or the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a bring-up (taken only when idle) |
| mode_usb | input | 1 | USB function selected |
| mode_dp | input | 1 | DisplayPort function selected |
| flip | input | 1 | Connector orientation reversed |
| lfps_en | output | 1 | Receive LFPS detector enable |
| pwr_en | output | 1 | PHY power enable |
| hold_pma_bus | output | 1 | PMA register-bus reset, 1 = held |
| hold_pcs_bus | output | 1 | PCS register-bus reset, 1 = held |
| hold_init | output | 1 | Init reset, 1 = held |
| hold_cmn | output | 1 | Common-block reset, 1 = held |
| hold_lane | output | 1 | Lane reset, 1 = held |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | 12 | Register write address |
| wr_data | output | 8 | Register write data |
| rd_en | output | 1 | Register read strobe |
| rd_addr | output | 12 | Register read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_en` |
| done | output | 1 | Bring-up finished (pulse) |
| error | output | 1 | PLL lock failed, resets rolled back (pulse) |
| cdr_late | output | 1 | Clock recovery lock not seen, valid with `done` |

## Verification
The assertions watch, on every cycle, the ordering invariants of the reset tree: bus resets never free without power, core resets never free while bus resets are held or outside USB mode, and the DisplayPort init write only appears in DP mode. They also watch the strobe shapes: single-cycle reads and outcome pulses, and a delay counter that only counts down. Which address and data each write carries, the pause after each table entry, the lane-mux value for each mode and orientation, the lane chosen for clock-recovery polling, the attempt counts and the unwinding order after a PLL failure only show up in the bench's scenarios. Those scenarios run against a register-file model with programmable lock latency.

// File: rtl/phy_bup_pkg.sv
// Package: shared widths, sequencer states and the table entry type.
// Assumes a 12-bit register address space and 8-bit register data.
package phy_bup_pkg;
    parameter int ADDR_W = 12;
    parameter int DATA_W = 8;
    parameter int DLY_W  = 4;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [DLY_W-1:0]  dly_us;
    } tbl_entry_t;

    typedef enum logic [4:0] {
        S_IDLE, S_LFPS, S_PWR, S_PMA, S_PCS, S_TWR, S_TWAIT, S_MUX, S_INIT,
        S_SETTLE, S_CMN, S_PRD, S_PWT, S_PCHK, S_GAP, S_FA, S_FB, S_DONE
    } seq_state_t;
endpackage

// File: rtl/bup_rom.sv
// Module: configuration table, generated from a closed formula per index.
// Assumes DEPTH >= 2 so the index has at least one bit.
module bup_rom
    import phy_bup_pkg::*;
#(
    parameter int              DEPTH = 8,
    parameter logic [ADDR_W-1:0] BASE = 12'h100,
    localparam int             IW    = $clog2(DEPTH)
) (
    input  logic [IW-1:0] idx,
    output tbl_entry_t    ent
);
    tbl_entry_t tbl [DEPTH];

    // one constant entry per index
    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        localparam logic [ADDR_W-1:0] A = BASE + ADDR_W'(4 * g);
        localparam logic [DATA_W-1:0] D = DATA_W'((37 * g + 5) % 256);
        localparam logic [DLY_W-1:0]  W = (g % 3 == 1) ? DLY_W'((g % 4) + 1) : '0;
        assign tbl[g] = '{addr: A, data: D, dly_us: W};
    end

    assign ent = tbl[idx];
endmodule

// File: rtl/bup_lane_mux.sv
// Module: derives the per-lane DP/USB selection from mode and orientation.
// Assumes bit n of the result = 1 places DisplayPort on lane n.
module bup_lane_mux (
    input  logic       usb,
    input  logic       dp,
    input  logic       flip,
    output logic [3:0] mux
);
    // pick the lane pattern for the current mode pair
    always_comb begin
        if (usb && dp)  mux = flip ? 4'b0011 : 4'b1100;
        else if (dp)    mux = 4'b1111;
        else            mux = 4'b0000;
    end
endmodule

// File: rtl/bup_timer.sv
// Module: down-counter used for table delays, settle time and poll gaps.
// Assumes load has priority; busy stays high while the count is non-zero.
module bup_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt;

    // load or count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R4
    timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && busy) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/phy_bringup_seq.sv
// Module: combo PHY bring-up sequencer (top).
// Drives the reset holds and power, plays the table, sets the lane mux,
// frees the core resets by mode and polls PLL / clock-recovery lock.
// Assumes read data is valid the cycle after rd_en and that the modes are
// stable at the start pulse (they are latched there).
module phy_bringup_seq
    import phy_bup_pkg::*;
#(
    parameter int              TBL_DEPTH  = 8,
    parameter int              CYC_PER_US = 8,
    parameter int              POLL_GAP   = 4,
    parameter int              POLL_MAX   = 6,
    parameter logic [11:0]     TBL_BASE   = 12'h100,
    parameter logic [11:0]     MUX_ADDR   = 12'h288,
    parameter logic [11:0]     DPRST_ADDR = 12'h28C,
    parameter logic [11:0]     PLL_ADDR   = 12'h0F0,
    parameter logic [11:0]     CDR0_ADDR  = 12'h8F0,
    parameter logic [11:0]     CDR2_ADDR  = 12'h9F0,
    parameter logic [7:0]      PLL_MASK   = 8'h03,
    parameter logic [7:0]      CDR_MASK   = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        mode_usb,
    input  logic        mode_dp,
    input  logic        flip,
    output logic        lfps_en,
    output logic        pwr_en,
    output logic        hold_pma_bus,
    output logic        hold_pcs_bus,
    output logic        hold_init,
    output logic        hold_cmn,
    output logic        hold_lane,
    output logic        wr_en,
    output logic [11:0] wr_addr,
    output logic [7:0]  wr_data,
    output logic        rd_en,
    output logic [11:0] rd_addr,
    input  logic [7:0]  rd_data,
    output logic        done,
    output logic        error,
    output logic        cdr_late
);
    localparam int IW         = $clog2(TBL_DEPTH);
    localparam int SETTLE_CYC = CYC_PER_US;
    localparam int DLY_MAX    = ((1 << DLY_W) - 1) * CYC_PER_US;
    localparam int TMAX_A     = (DLY_MAX > SETTLE_CYC) ? DLY_MAX : SETTLE_CYC;
    localparam int TMAX       = (TMAX_A > POLL_GAP) ? TMAX_A : POLL_GAP;
    localparam int TW         = $clog2(TMAX + 1);
    localparam int ATW        = $clog2(POLL_MAX + 1);

    seq_state_t       st;
    logic [IW-1:0]    idx;
    logic [ATW-1:0]   att;
    logic             usb_q, dp_q, flip_q, phase_pll, miss_q;
    tbl_entry_t       ent;
    logic [3:0]       mux;
    logic             tmr_load, tmr_busy, poll_ok, last_try;
    logic [TW-1:0]    tmr_val;

    bup_rom #(.DEPTH(TBL_DEPTH), .BASE(TBL_BASE)) i_rom (.idx(idx), .ent(ent));

    bup_lane_mux i_mux (.usb(usb_q), .dp(dp_q), .flip(flip_q), .mux(mux));

    bup_timer #(.W(TW)) i_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .busy(tmr_busy)
    );

    // evaluate the status word returned for the current poll
    always_comb begin
        poll_ok  = phase_pll ? ((rd_data & PLL_MASK) == PLL_MASK) : |(rd_data & CDR_MASK);
        last_try = (att == ATW'(POLL_MAX - 1));
    end

    // choose what the delay counter loads in each state
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st)
            S_TWR:  begin tmr_load = 1'b1; tmr_val = TW'(ent.dly_us) * TW'(CYC_PER_US); end
            S_INIT: begin tmr_load = 1'b1; tmr_val = TW'(SETTLE_CYC); end
            S_PCHK: begin tmr_load = !poll_ok && !last_try; tmr_val = TW'(POLL_GAP); end
            default: ;
        endcase
    end

    // sequence state, reset holds, bus strobes and outcome pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; idx <= '0; att <= '0;
            usb_q <= 1'b0; dp_q <= 1'b0; flip_q <= 1'b0; phase_pll <= 1'b1; miss_q <= 1'b0;
            lfps_en <= 1'b0; pwr_en <= 1'b0;
            hold_pma_bus <= 1'b1; hold_pcs_bus <= 1'b1;
            hold_init <= 1'b1; hold_cmn <= 1'b1; hold_lane <= 1'b1;
            wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0;
            rd_en <= 1'b0; rd_addr <= '0;
            done <= 1'b0; error <= 1'b0; cdr_late <= 1'b0;
        end else begin
            wr_en <= 1'b0; rd_en <= 1'b0;
            done <= 1'b0; error <= 1'b0; cdr_late <= 1'b0;
            case (st)
                S_IDLE: if (start) begin
                    usb_q <= mode_usb; dp_q <= mode_dp; flip_q <= flip;
                    lfps_en <= 1'b0; pwr_en <= 1'b0;
                    hold_pma_bus <= 1'b1; hold_pcs_bus <= 1'b1;
                    hold_init <= 1'b1; hold_cmn <= 1'b1; hold_lane <= 1'b1;
                    idx <= '0; miss_q <= 1'b0;
                    st <= S_LFPS;
                end
                S_LFPS: begin lfps_en <= usb_q; st <= S_PWR; end
                S_PWR:  begin pwr_en <= 1'b1; st <= S_PMA; end
                S_PMA:  begin hold_pma_bus <= 1'b0; st <= S_PCS; end
                S_PCS:  begin hold_pcs_bus <= 1'b0; st <= S_TWR; end
                S_TWR: begin
                    wr_en <= 1'b1; wr_addr <= ent.addr; wr_data <= ent.data;
                    st <= S_TWAIT;
                end
                S_TWAIT: if (!tmr_busy) begin
                    if (idx == IW'(TBL_DEPTH - 1)) st <= S_MUX;
                    else begin idx <= idx + 1'b1; st <= S_TWR; end
                end
                S_MUX: begin
                    wr_en <= 1'b1; wr_addr <= MUX_ADDR; wr_data <= {4'b0000, mux};
                    st <= S_INIT;
                end
                S_INIT: begin
                    if (usb_q) hold_init <= 1'b0;
                    if (dp_q) begin wr_en <= 1'b1; wr_addr <= DPRST_ADDR; wr_data <= 8'h01; end
                    st <= S_SETTLE;
                end
                S_SETTLE: if (!tmr_busy) st <= S_CMN;
                S_CMN: begin
                    if (usb_q) begin hold_cmn <= 1'b0; hold_lane <= 1'b0; end
                    att <= '0; phase_pll <= 1'b1;
                    st <= usb_q ? S_PRD : S_DONE;
                end
                S_PRD: begin
                    rd_en <= 1'b1;
                    rd_addr <= phase_pll ? PLL_ADDR : (flip_q ? CDR2_ADDR : CDR0_ADDR);
                    st <= S_PWT;
                end
                S_PWT: st <= S_PCHK;
                S_PCHK: begin
                    if (poll_ok) begin
                        if (phase_pll) begin phase_pll <= 1'b0; att <= '0; st <= S_PRD; end
                        else st <= S_DONE;
                    end else if (last_try) begin
                        if (phase_pll) st <= S_FA;
                        else begin miss_q <= 1'b1; st <= S_DONE; end
                    end else begin
                        att <= att + 1'b1; st <= S_GAP;
                    end
                end
                S_GAP: if (!tmr_busy) st <= S_PRD;
                S_FA: begin hold_init <= 1'b1; hold_cmn <= 1'b1; hold_lane <= 1'b1; st <= S_FB; end
                S_FB: begin
                    hold_pma_bus <= 1'b1; hold_pcs_bus <= 1'b1; error <= 1'b1;
                    st <= S_IDLE;
                end
                S_DONE: begin done <= 1'b1; cdr_late <= miss_q; st <= S_IDLE; end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R2
    bus_needs_power_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_pcs_bus || !hold_pma_bus) |-> pwr_en);
    // R7
    core_after_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_cmn || !hold_lane) |-> (!hold_init && !hold_pma_bus && !hold_pcs_bus));
    // R7
    core_usb_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_cmn) |-> usb_q);
    // R6
    dp_init_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == DPRST_ADDR) |-> dp_q);
    // R9
    read_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |=> (!done && !error));
    // R12
    outcome_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
endmodule

// File: tb/test_phy_bringup_seq.sv
module test_phy_bringup_seq;
    localparam int DEPTH = 8, CPU = 8, GAP = 4, PMAX = 6;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic mode_usb = 1'b0, mode_dp = 1'b0, flip = 1'b0;
    logic lfps_en, pwr_en, hold_pma_bus, hold_pcs_bus, hold_init, hold_cmn, hold_lane;
    logic wr_en, rd_en, done, error, cdr_late;
    logic [11:0] wr_addr, rd_addr;
    logic [7:0] wr_data, rd_data = 8'h00;

    always #2 clk = ~clk;

    phy_bringup_seq i_phy_bringup_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_usb(mode_usb), .mode_dp(mode_dp),
        .flip(flip), .lfps_en(lfps_en), .pwr_en(pwr_en), .hold_pma_bus(hold_pma_bus),
        .hold_pcs_bus(hold_pcs_bus), .hold_init(hold_init), .hold_cmn(hold_cmn),
        .hold_lane(hold_lane), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .done(done), .error(error),
        .cdr_late(cdr_late)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit finished = 0;
    int nw, wc[64], npll, ncdr, ndone, nerr, late_seen, pa, ca;
    int prev_pll_rd, min_pll_gap;
    logic [11:0] wa[64], cdr_addr;
    logic [7:0] wd[64];
    int t_lfps, t_pwr, t_pma, t_pcs, t_init, t_cmn, t_lane, r_init, r_pma;
    logic p_lfps, p_pwr, p_pma, p_pcs, p_init, p_cmn, p_lane;

    function automatic logic [11:0] e_addr(int i); return 12'(12'h100 + 4 * i); endfunction
    function automatic logic [7:0] e_data(int i); return 8'((37 * i + 5) % 256); endfunction
    function automatic int e_dly(int i); return (i % 3 == 1) ? (i % 4) + 1 : 0; endfunction
    function automatic logic [7:0] e_mux(bit u, bit d, bit f);
        if (u && d) return f ? 8'h03 : 8'h0C;
        if (d) return 8'h0F;
        return 8'h00;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // PHY register model and event monitor
    always @(posedge clk) begin
        cyc++;
        if (wr_en && nw < 64) begin wa[nw] = wr_addr; wd[nw] = wr_data; wc[nw] = cyc; nw++; end
        if (rd_en) begin
            if (rd_addr == 12'h0F0) begin
                rd_data <= (npll >= pa) ? 8'h03 : ((npll % 2) ? 8'h02 : 8'h01);
                if (prev_pll_rd >= 0 && cyc - prev_pll_rd < min_pll_gap) min_pll_gap = cyc - prev_pll_rd;
                prev_pll_rd = cyc;
                npll++;
            end else begin
                cdr_addr = rd_addr;
                rd_data <= (ncdr >= ca) ? 8'h01 : 8'h00;
                ncdr++;
            end
        end
        if (done) begin ndone++; if (cdr_late) late_seen = 1; end
        if (error) nerr++;
        if (!p_lfps && lfps_en && t_lfps < 0) t_lfps = cyc;
        if (!p_pwr && pwr_en && t_pwr < 0) t_pwr = cyc;
        if (p_pma && !hold_pma_bus && t_pma < 0) t_pma = cyc;
        if (p_pcs && !hold_pcs_bus && t_pcs < 0) t_pcs = cyc;
        if (p_init && !hold_init && t_init < 0) t_init = cyc;
        if (p_cmn && !hold_cmn && t_cmn < 0) t_cmn = cyc;
        if (p_lane && !hold_lane && t_lane < 0) t_lane = cyc;
        if (!p_init && hold_init) r_init = cyc;
        if (!p_pma && hold_pma_bus) r_pma = cyc;
        p_lfps = lfps_en; p_pwr = pwr_en; p_pma = hold_pma_bus; p_pcs = hold_pcs_bus;
        p_init = hold_init; p_cmn = hold_cmn; p_lane = hold_lane;
    end

    task automatic run_case(bit u, bit d, bit f, int pll_after, int cdr_after, bit poke);
        int wait_c, base;
        @(negedge clk);
        nw = 0; npll = 0; ncdr = 0; ndone = 0; nerr = 0; late_seen = 0; cdr_addr = '0;
        pa = pll_after; ca = cdr_after; prev_pll_rd = -1; min_pll_gap = 1000000;
        t_lfps = -1; t_pwr = -1; t_pma = -1; t_pcs = -1; t_init = -1; t_cmn = -1; t_lane = -1;
        r_init = -1; r_pma = -1;
        mode_usb = u; mode_dp = d; flip = f; start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (poke) begin
            while (nw < 3) @(negedge clk);
            mode_usb = ~u; mode_dp = ~d; flip = ~f; start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        wait_c = 0;
        while (ndone + nerr == 0 && wait_c < 20000) begin @(negedge clk); wait_c++; end
        repeat (4) @(negedge clk);
        mode_usb = u; mode_dp = d; flip = f;

        // R12 outcome
        if (u && pll_after >= PMAX) begin
            chk(nerr == 1 && ndone == 0, "R11 error outcome", nerr, 1);
            chk(npll == PMAX, "R9 pll attempts", npll, PMAX);
            chk(ncdr == 0, "R11 no cdr poll", ncdr, 0);
            chk(r_pma == r_init + 1, "R11 unwind order", r_pma - r_init, 1);
            chk(hold_init && hold_cmn && hold_lane && hold_pma_bus && hold_pcs_bus,
                "R11 holds reasserted", 0, 1);
        end else begin
            chk(ndone == 1 && nerr == 0, "R12 single done", ndone, 1);
        end
        // R2 power order
        if (u) chk(t_lfps >= 0 && t_lfps < t_pwr, "R2 lfps before power", t_lfps, t_pwr - 1);
        else chk(t_lfps < 0 && !lfps_en, "R2 lfps stays off", t_lfps, -1);
        chk(t_pwr >= 0 && t_pwr < t_pma && t_pma < t_pcs && t_pcs < wc[0],
            "R2 power/bus order", t_pcs, t_pma + 1);
        // R3/R4/R5/R6 writes
        base = DEPTH + 1 + (d ? 1 : 0);
        chk(nw == base, "R3 write count", nw, base);
        for (int i = 0; i < DEPTH; i++) begin
            chk(wa[i] == e_addr(i) && wd[i] == e_data(i), "R3 table entry", int'(wd[i]), int'(e_data(i)));
            if (i < DEPTH - 1)
                chk(wc[i+1] - wc[i] >= e_dly(i) * CPU && wc[i+1] - wc[i] <= e_dly(i) * CPU + 2,
                    "R4 entry gap", wc[i+1] - wc[i], e_dly(i) * CPU);
        end
        chk(wa[DEPTH] == 12'h288 && wd[DEPTH] == e_mux(u, d, f), "R5 lane mux",
            int'(wd[DEPTH]), int'(e_mux(u, d, f)));
        if (d) chk(wa[DEPTH+1] == 12'h28C && wd[DEPTH+1] == 8'h01, "R6 dp init write",
            int'(wa[DEPTH+1]), 'h28C);
        if (u) chk(t_init > wc[DEPTH], "R6 init after mux", t_init, wc[DEPTH] + 1);
        else chk(t_init < 0, "R6 init held without usb", t_init, -1);
        // R7 core resets
        if (u) chk(t_cmn >= t_init + CPU && t_lane == t_cmn, "R7 settle then cmn/lane",
            t_cmn - t_init, CPU);
        else chk(t_cmn < 0 && t_lane < 0, "R7 cmn/lane held", t_cmn, -1);
        // R8/R9/R10 polling
        if (!u) chk(npll + ncdr == 0, "R8 no polling", npll + ncdr, 0);
        else if (pll_after < PMAX) begin
            int ec = (cdr_after < PMAX) ? cdr_after + 1 : PMAX;
            chk(npll == pll_after + 1, "R9 pll reads", npll, pll_after + 1);
            chk(npll < 2 || min_pll_gap >= GAP, "R9 poll gap", min_pll_gap, GAP);
            chk(ncdr == ec, "R10 cdr reads", ncdr, ec);
            chk(cdr_addr == (f ? 12'h9F0 : 12'h8F0), "R10 cdr lane", int'(cdr_addr),
                f ? 'h9F0 : 'h8F0);
            chk(late_seen == (cdr_after >= PMAX), "R10 cdr_late flag", late_seen,
                int'(cdr_after >= PMAX));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk(hold_init && hold_cmn && hold_lane && hold_pma_bus && hold_pcs_bus,
            "R1 holds after reset", 0, 1);
        chk(!pwr_en && !lfps_en && !wr_en && !rd_en && !done && !error && !cdr_late,
            "R1 outputs idle", 1, 0);
        run_case(1, 1, 0, 0, 0, 0);
        run_case(1, 1, 1, 2, PMAX, 0);      // cdr timeout, flipped
        run_case(0, 1, 0, 0, 0, 0);         // DP only
        run_case(1, 0, 1, PMAX - 1, 1, 0);  // last PLL attempt passes
        run_case(1, 0, 0, PMAX, 0, 0);      // PLL timeout
        run_case(0, 0, 0, 0, 0, 0);         // no mode
        run_case(1, 1, 0, 1, 1, 1);         // R12 start ignored mid-run
        void'($urandom(32'd1234));
        for (int k = 0; k < 10; k++)
            run_case($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 8, $urandom % 8, 0);
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule